// File: doc/BRIEF.md
# Microprogrammed Next-State Sequencer

This block is the control unit of a small 16-bit multi-cycle processor. A 6-bit state register selects one microinstruction out of a 64-entry control store. Each microinstruction is 35 bits wide. A 26-bit control word drives the datapath. The other 9 bits tell the sequencer how to pick the next state: a dispatch flag, a 2-bit condition mode and a 6-bit jump target.

The next address needs no adder. When the dispatch flag is set, it is the opcode field of the instruction with zeros above it, which gives a 16-way fan-out. Otherwise it is the jump target, with at most one status bit ORed into one bit position. The condition mode picks that bit: the memory ready bit, the branch-enable bit or instruction bit 11.

The branch-enable bit is computed inside the block from the N, Z and P condition flags and instruction bits 11 to 9. The microinstruction is registered together with the state. The control word for a cycle is therefore stable from the start of that cycle.

The store holds a small test microprogram:

| From state | Goes to | Purpose |
|---|---|---|
| 18 or 19 | 33 | Fetch start |
| 33 | 33 until memory is ready, then 35 | Wait for memory |
| 35 | 32 | Fetch end |
| 32 | opcode | Decode |
| 0 | 22 or 18 | Branch |
| 4 | 21 or 20 | Addressing-mode selection |
| 2 | 29 | Start of a read |
| 29 | 29 until memory is ready, then 31 | Wait for memory |
| Any other state, including 1, 10, 11, 20, 21, 22 and 31 | 18 | Return to fetch |

Top module: `useq_control`

## Requirements
- R1: A synchronous active-high reset loads state 18 and clears the branch-enable bit.
- R2: Bit k of `ctrl_o` always equals bit (k mod 6) of the state shown on `state_o` in the same cycle. This is the test pattern of the control words, and it shows that the control word is registered in step with the state.
- R3: In unconditional mode (condition code 00) the next state is the jump target, and `mem_ready` and the flags have no effect. States 18 and 19 go to 33, and state 35 goes to 32 even when `mem_ready` is 1.
- R4: In memory-wait mode (condition code 01) the ready bit is ORed into bit 1 of the jump target. State 33 repeats while `mem_ready` is 0 and moves to 35 when it is 1. State 29 behaves the same way and moves to 31.
- R5: When the dispatch flag is set (state 32), the next state is {2'b00, instr[15:12]}. For example, opcode 0001 goes to state 1.
- R6: The unused opcodes 1010 and 1011 are dispatched to states 10 and 11, where the illegal-opcode sequence starts.
- R7: In decode state 32 the branch-enable bit loads (instr[11] & N) | (instr[10] & Z) | (instr[9] & P). In all other states it holds its value.
- R8: In branch mode (condition code 10) the branch-enable bit is ORed into bit 2 of the jump target. State 0 goes to 22 when the bit is set and to 18 when it is clear.
- R9: In addressing-mode selection (condition code 11) instr[11] is ORed into bit 0 of the jump target. State 4 goes to 21 when instr[11] is 1 and to 20 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_ready | input | 1 | Memory reports that the current access completes this cycle |
| instr | input | 16 | Instruction register contents (bits 15:9 are used) |
| cc_n | input | 1 | Negative condition flag |
| cc_z | input | 1 | Zero condition flag |
| cc_p | input | 1 | Positive condition flag |
| state_o | output | 6 | Current state (control-store address) |
| ctrl_o | output | 26 | Registered datapath control word of the current state |

## Verification
Some rules hold on every cycle, and the assertions check them:
- the state after a reset;
- the stall in the fetch wait while ready is low, and its exit once ready is high;
- the generic hold of memory-wait mode;
- the zero-extended opcode dispatch;
- the loading of the branch-enable bit only in decode, and its hold everywhere else.

Other behaviours depend on the test microprogram and on the instruction stream, so only the bench scenarios can show them:
- that a taken and a not-taken branch end in different states;
- that both addressing-mode targets are reached;
- that illegal opcodes land on their handlers;
- that the second memory wait exits to 31;
- that ready is ignored in unconditional states;
- that the control word tracks the state through a whole instruction.

// File: rtl/useq_pkg.sv
package useq_pkg;
   // Geometry of the control store and the microinstruction
   localparam int STATE_W = 6;
   localparam int CTRL_W  = 26;
   localparam int OPC_W   = 4;
   localparam int STORE_D = 1 << STATE_W;
   localparam int UWORD_W = CTRL_W + 1 + 2 + STATE_W;

   // Bit positions of the jump target that each condition mode may set
   localparam int RDY_BIT  = 1;
   localparam int BEN_BIT  = 2;
   localparam int MODE_BIT = 0;

   // Well-known states of the test microprogram
   localparam logic [STATE_W-1:0] ST_BRANCH    = 6'd0;
   localparam logic [STATE_W-1:0] ST_READ      = 6'd2;
   localparam logic [STATE_W-1:0] ST_AMODE     = 6'd4;
   localparam logic [STATE_W-1:0] ST_FETCH0    = 6'd18;
   localparam logic [STATE_W-1:0] ST_FETCH1    = 6'd19;
   localparam logic [STATE_W-1:0] ST_AMODE_LO  = 6'd20;
   localparam logic [STATE_W-1:0] ST_RD_WAIT   = 6'd29;
   localparam logic [STATE_W-1:0] ST_DECODE    = 6'd32;
   localparam logic [STATE_W-1:0] ST_FETCH_MEM = 6'd33;
   localparam logic [STATE_W-1:0] ST_FETCH_IR  = 6'd35;

   typedef enum logic [1:0] {
      CND_JUMP   = 2'b00,
      CND_MEMRDY = 2'b01,
      CND_BRANCH = 2'b10,
      CND_AMODE  = 2'b11
   } cond_e;

   typedef struct packed {
      logic [CTRL_W-1:0]  ctrl;
      logic               ird;
      cond_e              cond;
      logic [STATE_W-1:0] jump;
   } uword_t;
endpackage

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
(
   input  logic [STATE_W-1:0] addr,
   output uword_t             word
);
   // Fill the control word with a pattern taken from the address, so that a
   // word read from the wrong address can be seen on the control outputs.
   function automatic logic [CTRL_W-1:0] ctrl_pattern(input logic [STATE_W-1:0] a);
      logic [CTRL_W-1:0] c;
      for (int k = 0; k < CTRL_W; k++) begin
         c[k] = a[k % STATE_W];
      end
      return c;
   endfunction

   // The test microprogram. Any state not listed returns to fetch.
   function automatic uword_t rom_word(input logic [STATE_W-1:0] a);
      uword_t w;
      w.ctrl = ctrl_pattern(a);
      w.ird  = 1'b0;
      w.cond = CND_JUMP;
      w.jump = ST_FETCH0;
      case (a)
         ST_FETCH0, ST_FETCH1: w.jump = ST_FETCH_MEM;
         ST_FETCH_MEM: begin
            w.cond = CND_MEMRDY;
            w.jump = ST_FETCH_MEM;
         end
         ST_FETCH_IR:  w.jump = ST_DECODE;
         ST_DECODE: begin
            w.ird  = 1'b1;
            w.jump = ST_DECODE;
         end
         ST_BRANCH: begin
            w.cond = CND_BRANCH;
            w.jump = ST_FETCH0;
         end
         ST_AMODE: begin
            w.cond = CND_AMODE;
            w.jump = ST_AMODE_LO;
         end
         ST_READ:      w.jump = ST_RD_WAIT;
         ST_RD_WAIT: begin
            w.cond = CND_MEMRDY;
            w.jump = ST_RD_WAIT;
         end
         default: ;
      endcase
      return w;
   endfunction

   always_comb begin
      word = rom_word(addr);
   end

   initial begin
      assert ($bits(uword_t) == UWORD_W) else $fatal(1, "microinstruction width mismatch");
      assert (STORE_D <= 64) else $fatal(1, "control store deeper than the address allows");
   end
endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
(
   input  logic               ird,
   input  cond_e              cond,
   input  logic [STATE_W-1:0] jump,
   input  logic               ready,
   input  logic               ben,
   input  logic               mode_bit,
   input  logic [OPC_W-1:0]   opcode,
   output logic [STATE_W-1:0] nxt
);
   logic [STATE_W-1:0] disp;
   logic [STATE_W-1:0] or_mask;

   // Dispatch address: the opcode with zeros above it
   generate
      if (STATE_W > OPC_W) begin : g_pad
         assign disp = {{(STATE_W-OPC_W){1'b0}}, opcode};
      end else begin : g_trunc
         assign disp = opcode[STATE_W-1:0];
      end
      if (RDY_BIT >= STATE_W || BEN_BIT >= STATE_W || MODE_BIT >= STATE_W) begin : g_bad_bits
         initial $fatal(1, "condition bit position outside the state field");
      end
   endgenerate

   // One status bit is placed in one position, chosen by the mode
   always_comb begin
      or_mask = '0;
      unique case (cond)
         CND_JUMP:   ;
         CND_MEMRDY: or_mask[RDY_BIT]  = ready;
         CND_BRANCH: or_mask[BEN_BIT]  = ben;
         CND_AMODE:  or_mask[MODE_BIT] = mode_bit;
      endcase
   end

   always_comb begin
      if (ird) nxt = disp;
      else     nxt = jump | or_mask;
   end
endmodule

// File: rtl/useq_ben.sv
module useq_ben
   import useq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  logic [2:0] sel,
   input  logic [2:0] flags,
   output logic       ben
);
   logic ben_q;

   always_ff @(posedge clk) begin
      if (rst)       ben_q <= 1'b0;
      else if (load) ben_q <= |(sel & flags);
   end

   assign ben = ben_q;
endmodule

// File: rtl/useq_control.sv
module useq_control
   import useq_pkg::*;
#(
   parameter logic [STATE_W-1:0] RESET_ST  = ST_FETCH0,
   parameter logic [STATE_W-1:0] DECODE_ST = ST_DECODE
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               mem_ready,
   input  logic [15:0]        instr,
   input  logic               cc_n,
   input  logic               cc_z,
   input  logic               cc_p,
   output logic [STATE_W-1:0] state_o,
   output logic [CTRL_W-1:0]  ctrl_o
);
   localparam int OPC_LSB = 16 - OPC_W;

   logic [STATE_W-1:0] state_q;
   uword_t             uinst_q;
   uword_t             word_d;
   logic [STATE_W-1:0] nxt;
   logic [STATE_W-1:0] store_addr;
   logic               ben_q;
   logic               unused_ir;

   assign unused_ir = ^instr[8:0];

   useq_next u_next (
      .ird      (uinst_q.ird),
      .cond     (uinst_q.cond),
      .jump     (uinst_q.jump),
      .ready    (mem_ready),
      .ben      (ben_q),
      .mode_bit (instr[11]),
      .opcode   (instr[15:OPC_LSB]),
      .nxt      (nxt)
   );

   // A single store read serves both the reset word and the next word
   assign store_addr = rst ? RESET_ST : nxt;

   useq_store u_store (
      .addr (store_addr),
      .word (word_d)
   );

   useq_ben u_ben (
      .clk   (clk),
      .rst   (rst),
      .load  (state_q == DECODE_ST),
      .sel   (instr[11:9]),
      .flags ({cc_n, cc_z, cc_p}),
      .ben   (ben_q)
   );

   always_ff @(posedge clk) begin
      state_q <= store_addr;
      uinst_q <= word_d;
   end

   assign state_o = state_q;
   assign ctrl_o  = uinst_q.ctrl;

   initial begin
      assert (OPC_W < 16) else $fatal(1, "opcode field wider than the instruction");
   end

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (state_q == RESET_ST && !ben_q)) else $error("reset state");        // R1
   AST_FETCH_STALL: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_FETCH_MEM && !mem_ready) |=> state_q == ST_FETCH_MEM) else $error("fetch stall");   // R4
   AST_FETCH_EXIT: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_FETCH_MEM && mem_ready) |=> state_q == ST_FETCH_IR) else $error("fetch exit");      // R4
   AST_MEMRDY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!uinst_q.ird && uinst_q.cond == CND_MEMRDY && !mem_ready) |=> state_q == $past(state_q)) else $error("wait hold"); // R4
   AST_DISPATCH: assert property (@(posedge clk) disable iff (rst)
      uinst_q.ird |=> (state_q[OPC_W-1:0] == $past(instr[15:OPC_LSB]) &&
                       state_q[STATE_W-1:OPC_W] == '0)) else $error("dispatch");       // R5
   AST_BEN_HOLD: assert property (@(posedge clk) disable iff (rst)
      (state_q != DECODE_ST) |=> $stable(ben_q)) else $error("ben hold");                // R7
   AST_BEN_LOAD: assert property (@(posedge clk) disable iff (rst)
      (state_q == DECODE_ST) |=> ben_q == $past((instr[11] & cc_n) | (instr[10] & cc_z) |
                                                (instr[9] & cc_p))) else $error("ben load"); // R7
endmodule

// File: tb/tb_useq_control.sv
`timescale 1ns/1ps
module tb_useq_control;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mem_ready = 1'b0;
   logic [15:0] instr = '0;
   logic        cc_n = 1'b0, cc_z = 1'b0, cc_p = 1'b0;
   logic [5:0]  state_o;
   logic [25:0] ctrl_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [5:0] st;
      int         req;
   } exp_t;
   exp_t expq[$];

   always #10 clk = ~clk;

   useq_control dut (
      .clk(clk), .rst(rst), .mem_ready(mem_ready), .instr(instr),
      .cc_n(cc_n), .cc_z(cc_z), .cc_p(cc_p),
      .state_o(state_o), .ctrl_o(ctrl_o)
   );

   function automatic logic [25:0] exp_ctrl(input logic [5:0] st);
      logic [25:0] c;
      for (int k = 0; k < 26; k++) c[k] = st[k % 6];
      return c;
   endfunction

   // Driver: drive one cycle of inputs and push the state expected after the edge
   task automatic drive(input logic r, input logic rdy, input logic [15:0] ir,
                        input logic [2:0] nzp, input logic [5:0] st, input int rq);
      exp_t e;
      @(negedge clk);
      rst = r; mem_ready = rdy; instr = ir;
      {cc_n, cc_z, cc_p} = nzp;
      e.st = st; e.req = rq;
      expq.push_back(e);
   endtask

   // From state 18 through fetch and decode up to the dispatched state
   task automatic fetch_decode(input logic [15:0] ir, input logic [2:0] nzp);
      drive(0, 1'b1, ir, nzp, 6'd33, 3);                  // R3 ready ignored in 18
      drive(0, 1'b0, ir, nzp, 6'd33, 4);                  // R4 stall
      drive(0, 1'b0, ir, nzp, 6'd33, 4);                  // R4 stall
      drive(0, 1'b1, ir, nzp, 6'd35, 4);                  // R4 exit
      drive(0, 1'b1, ir, nzp, 6'd32, 3);                  // R3 ready ignored in 35
      drive(0, 1'b0, ir, nzp, {2'b00, ir[15:12]}, 5);     // R5 dispatch
   endtask

   // Monitor: pop and compare away from the clock edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            checks++;
            if (state_o !== e.st) begin
               errors++;
               $display("FAIL R%0d: state actual %0d expected %0d", e.req, state_o, e.st);
            end
            checks++;
            if (ctrl_o !== exp_ctrl(e.st)) begin
               errors++;
               $display("FAIL R2: ctrl actual %h expected %h", ctrl_o, exp_ctrl(e.st));
            end
         end
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      drive(1, 0, 16'h0000, 3'b000, 6'd18, 1);            // R1 reset state
      drive(1, 1, 16'hFFFF, 3'b111, 6'd18, 1);            // R1 inputs ignored in reset
      // ADD: opcode 0001 to state 1
      fetch_decode(16'h1000, 3'b000);
      drive(0, 1, 16'h1000, 3'b000, 6'd18, 3);            // R3
      // Branch taken via Z: R7 loads 1, R8 goes to 22
      fetch_decode(16'h0400, 3'b010);
      drive(0, 0, 16'h0400, 3'b000, 6'd22, 8);            // R8 R7 flags cleared later ignored
      drive(0, 0, 16'h0400, 3'b000, 6'd18, 3);
      // Branch not taken: N selected, only Z set
      fetch_decode(16'h0800, 3'b010);
      drive(0, 0, 16'h0800, 3'b111, 6'd18, 8);            // R8 R7
      // Branch taken via P
      fetch_decode(16'h0200, 3'b001);
      drive(0, 0, 16'h0200, 3'b000, 6'd22, 8);            // R8 R7
      drive(0, 0, 16'h0200, 3'b000, 6'd18, 3);
      // Addressing-mode selection, both values of instr[11]
      fetch_decode(16'h4800, 3'b000);
      drive(0, 0, 16'h4800, 3'b000, 6'd21, 9);            // R9
      drive(0, 0, 16'h4800, 3'b000, 6'd18, 3);
      fetch_decode(16'h4000, 3'b000);
      drive(0, 0, 16'h4000, 3'b000, 6'd20, 9);            // R9
      drive(0, 0, 16'h4000, 3'b000, 6'd18, 3);
      // Unused opcodes
      fetch_decode(16'hA000, 3'b000);                     // R6 lands on 10
      drive(0, 0, 16'hA000, 3'b000, 6'd18, 6);
      fetch_decode(16'hB000, 3'b000);                     // R6 lands on 11
      drive(0, 0, 16'hB000, 3'b000, 6'd18, 6);
      // Read path: second memory wait exits to 31
      fetch_decode(16'h2000, 3'b000);
      drive(0, 0, 16'h2000, 3'b000, 6'd29, 3);
      drive(0, 0, 16'h2000, 3'b000, 6'd29, 4);            // R4
      drive(0, 1, 16'h2000, 3'b000, 6'd31, 4);            // R4
      drive(0, 0, 16'h2000, 3'b000, 6'd18, 3);
      // Reset in the middle of fetch
      drive(0, 0, 16'h0000, 3'b000, 6'd33, 3);
      drive(1, 1, 16'h0000, 3'b000, 6'd18, 1);            // R1
      // Branch with no flag selected after reset
      fetch_decode(16'h0E00, 3'b000);
      drive(0, 0, 16'h0E00, 3'b111, 6'd18, 8);            // R8 R7
      while (expq.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule